// File: doc/BRIEF.md
# Four-State Memristive Hyperchaotic Oscillator

This block generates a hyperchaotic signal set in fixed-point arithmetic. Four state registers x, y, z and u hold the state of a memristive oscillator. The nonlinearity is a flux-controlled memristor term, x·u². Each pulse on `step_en_i` advances the system by one forward-Euler step with step size T = 0.001. All four next-state values are computed from the current values by multipliers and adders, and they are written in the same clock edge.

The coefficients are folded with T ahead of time into seven products: T·a, T·a·m0, T·a·m1, T·b·d, T·b, T·c and T·n. The block loads these, together with the initial state, into registers at reset. The defaults are a=7, b=1, c=2.5, d=1, m0=−1.2, m1=1, n=−6 and start state (0.1, 0, 0, 0). With these values the states wander chaotically within roughly ±5.

The four states are presented on output ports at all times. A one-cycle strobe marks each freshly committed step. A downstream consumer, such as a chaotic modulator, samples the states on that strobe.

Top module: `hc_oscillator`

## Requirements
- R1: While `rst_ni` is low, the outputs show the initial state and `valid_o` is 0. With default parameters the outputs are x_o=0x0019999A (0.1), y_o=0, z_o=0 and u_o=0.
- R2: All values are signed 32-bit with 24 fraction bits. A product k·s is formed exactly and then shifted right arithmetically by 24 bits, which rounds toward minus infinity. A step sets x to x + ⌊Ta·z⌋ − ⌊Tam0·x⌋ − ⌊Tam1·w⌋. Here w = sat(⌊x·q⌋) and q = sat(⌊u·u⌋).
- R3: A step sets y to y + ⌊Tbd·y⌋ − ⌊Tb·z⌋ and z to z + ⌊Tc·y⌋ − ⌊Tc·x⌋. z therefore keeps its value when x equals y.
- R4: A step sets u to u + ⌊Tn·x⌋. u therefore keeps its value when x is zero.
- R5: Each new state, and the intermediates q and w, saturate to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R6: When `step_en_i` is low at a clock edge, all four states keep their values.
- R7: `valid_o` is 1 in exactly the cycles that follow an edge at which `step_en_i` was high.
- R8: Every update reads only the pre-step values of all four states, and all four commit in the same edge.
- R9: With default parameters the states stay within ±16.0 over 20,000+ steps and move away from the start point by more than 0.25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads coefficients and initial state |
| step_en_i | input | 1 | Advance one Euler step at this edge |
| x_o | output | 32 | State x, Q8.24 |
| y_o | output | 32 | State y, Q8.24 |
| z_o | output | 32 | State z, Q8.24 |
| u_o | output | 32 | State u (memristor flux), Q8.24 |
| valid_o | output | 1 | Pulses for one cycle after each committed step |

## Verification
The hardest behaviour to reach from the ports is saturation. With the default coefficients the states stay within ±5, far inside the ±128 range, so neither the state adders nor the squared-flux intermediates ever clip. The bench therefore runs a second instance alongside the first. That instance starts at x=120 with a strong linear gain on x and a flux gain of −1. Within two steps x is driven into the positive limit, u into the negative limit, and u² and x·u² into their clip values. Both instances share an irregular enable pattern with isolated gaps and one long idle run. Every cycle is compared against an integer reference model.

// File: rtl/hc_pkg.sv
package hc_pkg;
  parameter int DATA_W = 32;
  parameter int FRAC_W = 24;
  parameter int ACC_W  = 2 * DATA_W;
  parameter int NUM_ST = 4;
  parameter int NUM_LIN = 8;

  localparam int IX = 0;
  localparam int IY = 1;
  localparam int IZ = 2;
  localparam int IU = 3;

  typedef logic signed [DATA_W-1:0] fx_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  typedef struct packed {
    fx_t ta;
    fx_t tam0;
    fx_t tam1;
    fx_t tbd;
    fx_t tb;
    fx_t tc;
    fx_t tn;
  } coef_t;

  localparam acc_t FX_MAX = (acc_t'(1) <<< (DATA_W - 1)) - acc_t'(1);
  localparam acc_t FX_MIN = -(acc_t'(1) <<< (DATA_W - 1));

  function automatic fx_t sat_fx(input acc_t v);
    acc_t r;
    if (v > FX_MAX)      r = FX_MAX;
    else if (v < FX_MIN) r = FX_MIN;
    else                 r = v;
    return r[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/hc_fxmul.sv
module hc_fxmul
  import hc_pkg::*;
(
  input  fx_t  a_i,
  input  fx_t  b_i,
  output acc_t p_o
);
  acc_t prod;
  // exact product, then floor to Q.FRAC_W
  assign prod = acc_t'(a_i) * acc_t'(b_i);
  assign p_o  = prod >>> FRAC_W;
endmodule

// File: rtl/hc_deriv.sv
module hc_deriv
  import hc_pkg::*;
(
  input  coef_t coef_i,
  input  fx_t   st_i    [NUM_ST],
  output acc_t  delta_o [NUM_ST]
);
  acc_t sq_raw, xu2_raw;
  fx_t  sq, xu2;
  fx_t  lin_a [NUM_LIN];
  fx_t  lin_b [NUM_LIN];
  acc_t lin_p [NUM_LIN];

  // memristor chain: u^2 then x*u^2, each clipped
  hc_fxmul u_sq  (.a_i(st_i[IU]), .b_i(st_i[IU]), .p_o(sq_raw));
  assign sq = sat_fx(sq_raw);
  hc_fxmul u_xu2 (.a_i(st_i[IX]), .b_i(sq), .p_o(xu2_raw));
  assign xu2 = sat_fx(xu2_raw);

  always_comb begin
    lin_a[0] = coef_i.ta;   lin_b[0] = st_i[IZ];
    lin_a[1] = coef_i.tam0; lin_b[1] = st_i[IX];
    lin_a[2] = coef_i.tam1; lin_b[2] = xu2;
    lin_a[3] = coef_i.tbd;  lin_b[3] = st_i[IY];
    lin_a[4] = coef_i.tb;   lin_b[4] = st_i[IZ];
    lin_a[5] = coef_i.tc;   lin_b[5] = st_i[IY];
    lin_a[6] = coef_i.tc;   lin_b[6] = st_i[IX];
    lin_a[7] = coef_i.tn;   lin_b[7] = st_i[IX];
  end

  for (genvar k = 0; k < NUM_LIN; k++) begin : g_lin
    hc_fxmul u_mul (.a_i(lin_a[k]), .b_i(lin_b[k]), .p_o(lin_p[k]));
  end

  assign delta_o[IX] = lin_p[0] - lin_p[1] - lin_p[2];
  assign delta_o[IY] = lin_p[3] - lin_p[4];
  assign delta_o[IZ] = lin_p[5] - lin_p[6];
  assign delta_o[IU] = lin_p[7];
endmodule

// File: rtl/hc_state.sv
module hc_state
  import hc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_en_i,
  input  fx_t  init_i  [NUM_ST],
  input  acc_t delta_i [NUM_ST],
  output fx_t  st_o    [NUM_ST]
);
  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    fx_t  st_q;
    acc_t sum;
    assign sum = acc_t'(st_q) + delta_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        st_q <= init_i[i];
      else if (step_en_i) st_q <= sat_fx(sum);
    end
    assign st_o[i] = st_q;
  end
endmodule

// File: rtl/hc_oscillator.sv
module hc_oscillator
  import hc_pkg::*;
#(
  parameter fx_t P_TA   = 117441,
  parameter fx_t P_TAM0 = -140929,
  parameter fx_t P_TAM1 = 117441,
  parameter fx_t P_TBD  = 16777,
  parameter fx_t P_TB   = 16777,
  parameter fx_t P_TC   = 41943,
  parameter fx_t P_TN   = -100663,
  parameter fx_t P_X0   = 1677722,
  parameter fx_t P_Y0   = 0,
  parameter fx_t P_Z0   = 0,
  parameter fx_t P_U0   = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_en_i,
  output logic signed [DATA_W-1:0] x_o,
  output logic signed [DATA_W-1:0] y_o,
  output logic signed [DATA_W-1:0] z_o,
  output logic signed [DATA_W-1:0] u_o,
  output logic                     valid_o
);
  localparam coef_t COEF_INIT = '{ta: P_TA, tam0: P_TAM0, tam1: P_TAM1,
                                  tbd: P_TBD, tb: P_TB, tc: P_TC, tn: P_TN};

  coef_t coef_q;
  fx_t   init_v [NUM_ST];
  fx_t   st     [NUM_ST];
  acc_t  delta  [NUM_ST];
  logic  valid_q;

  // coefficient bank, loaded at reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_q <= COEF_INIT;
    else         coef_q <= coef_q;
  end

  assign init_v[IX] = P_X0;
  assign init_v[IY] = P_Y0;
  assign init_v[IZ] = P_Z0;
  assign init_v[IU] = P_U0;

  hc_deriv u_deriv (.coef_i(coef_q), .st_i(st), .delta_o(delta));

  hc_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_en_i(step_en_i),
    .init_i   (init_v),
    .delta_i  (delta),
    .st_o     (st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= step_en_i;
  end

  assign x_o     = st[IX];
  assign y_o     = st[IY];
  assign z_o     = st[IZ];
  assign u_o     = st[IU];
  assign valid_o = valid_q;
endmodule

// File: rtl/hc_oscillator_chk.sv
module hc_oscillator_chk
  import hc_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic step_en_i,
  input fx_t  x_o,
  input fx_t  y_o,
  input fx_t  z_o,
  input fx_t  u_o,
  input logic valid_o
);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> ($stable(x_o) && $stable(y_o) && $stable(z_o) && $stable(u_o)));

  assert_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i |=> valid_o);

  assert_no_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> !valid_o);

  assert_z_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && x_o == y_o) |=> $stable(z_o));

  assert_u_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && x_o == '0) |=> $stable(u_o));

  assert_x_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && x_o == '0 && z_o == '0) |=> $stable(x_o));
endmodule

bind hc_oscillator hc_oscillator_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .step_en_i(step_en_i),
  .x_o      (x_o),
  .y_o      (y_o),
  .z_o      (z_o),
  .u_o      (u_o),
  .valid_o  (valid_o)
);

// File: tb/hc_oscillator_tb.sv
module hc_oscillator_tb;
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;
  localparam int     NCYC = 30000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic step_en_i = 1'b0;
  logic signed [31:0] d_st [2][4];
  logic d_valid [2];

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model: [instance][state], coefficients ta,tam0,tam1,tbd,tb,tc,tn
  longint m_st [2][4];
  longint m_init [2][4];
  longint cf [2][7];
  bit exp_valid;
  bit prev_step;
  longint peak_main;
  bit hit_max_x, hit_min_u;

  always #5 clk_i = ~clk_i;

  hc_oscillator u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_en_i(step_en_i),
    .x_o(d_st[0][0]), .y_o(d_st[0][1]), .z_o(d_st[0][2]), .u_o(d_st[0][3]),
    .valid_o(d_valid[0])
  );

  hc_oscillator #(
    .P_TAM0(-32'sd8388608), .P_TN(-32'sd16777216), .P_X0(32'sd2013265920)
  ) u_sat (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_en_i(step_en_i),
    .x_o(d_st[1][0]), .y_o(d_st[1][1]), .z_o(d_st[1][2]), .u_o(d_st[1][3]),
    .valid_o(d_valid[1])
  );

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint fm(input longint a, input longint b);
    return (a * b) >>> 24;
  endfunction

  task automatic advance(input int k);
    longint x, y, z, u, q, w, nx, ny, nz, nu;
    x = m_st[k][0]; y = m_st[k][1]; z = m_st[k][2]; u = m_st[k][3];
    q  = sat(fm(u, u));
    w  = sat(fm(x, q));
    nx = sat(x + fm(cf[k][0], z) - fm(cf[k][1], x) - fm(cf[k][2], w));
    ny = sat(y + fm(cf[k][3], y) - fm(cf[k][4], z));
    nz = sat(z + fm(cf[k][5], y) - fm(cf[k][5], x));
    nu = sat(u + fm(cf[k][6], x));
    m_st[k][0] = nx; m_st[k][1] = ny; m_st[k][2] = nz; m_st[k][3] = nu;
  endtask

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input bit in_reset);
    string tg;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 4; i++) begin
        if (in_reset)        tg = "R1 reset state";
        else if (!prev_step) tg = "R6 hold";
        else if (k == 1)     tg = "R5 saturating step";
        else if (i == 0)     tg = "R2 R8 x step";
        else if (i == 3)     tg = "R4 R8 u step";
        else                 tg = "R3 R8 y/z step";
        check(tg, longint'(d_st[k][i]), m_st[k][i]);
      end
      check("R7 valid", longint'(d_valid[k]), longint'(exp_valid));
    end
  endtask

  initial begin
    cf[0] = '{117441, -140929, 117441, 16777, 16777, 41943, -100663};
    cf[1] = '{117441, -8388608, 117441, 16777, 16777, 41943, -16777216};
    m_init[0] = '{1677722, 0, 0, 0};
    m_init[1] = '{2013265920, 0, 0, 0};
    m_st = m_init;
    exp_valid = 0;
    prev_step = 0;
    peak_main = 0;
    hit_max_x = 0;
    hit_min_u = 0;

    repeat (3) @(negedge clk_i);
    compare_all(1'b1);                       // R1
    check("R1 default x0 is 0x0019999A", longint'(d_st[0][0]), 64'sd1677722);
    rst_ni = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk_i);
      compare_all(1'b0);
      for (int i = 0; i < 4; i++) begin
        longint a;
        a = longint'(d_st[0][i]);
        if (a < 0) a = -a;
        if (a > peak_main) peak_main = a;
      end
      if (longint'(d_st[1][0]) == MAXV) hit_max_x = 1;
      if (longint'(d_st[1][3]) == MINV) hit_min_u = 1;
      step_en_i = ((cyc % 9) != 4) && !(cyc >= 1000 && cyc < 1012);
      if (step_en_i) begin
        advance(0);
        advance(1);
      end
      exp_valid = step_en_i;
      prev_step = step_en_i;
    end

    check("R5 x reached positive limit", longint'(hit_max_x), 1);
    check("R5 u reached negative limit", longint'(hit_min_u), 1);
    check("R9 peak within 16.0", longint'(peak_main < (64'sd16 <<< 24)), 1);
    check("R9 peak exceeds 0.25", longint'(peak_main > (64'sd1 <<< 22)), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule